// File: doc/BRIEF.md
# UART FIFO Control and DMA Ready Signalling

This block sits beside the transmit and receive FIFOs of a 16550-style UART. It decodes writes to the write-only FIFO control byte, keeps the settings that must persist (enable, ready-pin mode and receive trigger level), and turns the clear requests into single-cycle pulses for the FIFO storage. The FIFOs report their occupancy and the receive timeout flag back to this block. The storage itself and the serializers live elsewhere.

From those counts the block derives a receive trigger indication and the two active-low DMA request pins, `rxrdy_n` and `txrdy_n`. Each pin has two signalling rules, selected by the mode bit. In the first rule the pins simply follow empty and non-empty. In the second rule they are sticky: the receive pin asserts at the trigger level or on a timeout and holds until the FIFO drains, and the transmit pin asserts on empty and holds until the FIFO is completely full. When the FIFOs are disabled, the block treats each direction as a single holding register of depth one.

Top module: `uart_fifo_ctl`

## Requirements
- R1: While reset is asserted, and in the cycles after it with both counts at zero, `rxrdy_n` is 1, `txrdy_n` is 0, both clear pulses are 0, and `fifo_en` and `dma_mode1` are 0.
- R2: A control write stores bit 0 as the FIFO enable, bit 3 as the ready-pin mode select and bits 7:6 as the trigger code. `fifo_en` and `dma_mode1` show the stored bits from the cycle after the write.
- R3: A control write with bit 1 set drives `rx_clear` high for exactly the one cycle after the write. The bit is not stored.
- R4: A control write with bit 2 set drives `tx_clear` high for exactly the one cycle after the write. The bit is not stored.
- R5: A control write whose bit 0 differs from the stored enable pulses both `rx_clear` and `tx_clear`. A write that leaves the enable unchanged, with bits 1 and 2 clear, pulses neither.
- R6: `rx_trig_reached` follows `rx_count` and the stored settings combinationally. With the FIFOs enabled it is high when `rx_count` is at least the level chosen by the trigger code: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. With the FIFOs disabled the level is 1 whatever the code.
- R7: In mode 0, or with the FIFOs disabled, `rxrdy_n` is low in the cycle after `rx_count` was non-zero and high in the cycle after it was zero.
- R8: In mode 1 with the FIFOs enabled, `rxrdy_n` goes low in the cycle after the trigger was reached or `rx_timeout` was high with data present. It then stays low until the cycle after `rx_count` reaches zero.
- R9: In mode 0, `txrdy_n` is low in the cycle after `tx_count` was zero and high in the cycle after it was at least one.
- R10: In mode 1 with the FIFOs enabled, `txrdy_n` goes low in the cycle after `tx_count` was zero. It goes high only in the cycle after `tx_count` equalled DEPTH, and otherwise keeps its previous value.
- R11: With the FIFOs disabled, the stored mode bit has no effect. The transmit FIFO counts as full at one character, so `txrdy_n` is high whenever one character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_wr | input | 1 | Write strobe for the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte being written |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_timeout | input | 1 | Receive character timeout flag |
| rx_clear | output | 1 | One-cycle pulse that empties the receive FIFO |
| tx_clear | output | 1 | One-cycle pulse that empties the transmit FIFO |
| fifo_en | output | 1 | Stored FIFO enable |
| dma_mode1 | output | 1 | Stored ready-pin mode select |
| rx_trig_reached | output | 1 | Receive occupancy at or above the trigger level |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| txrdy_n | output | 1 | Active-low transmit DMA request |

## Verification
The receive count is swept from 0 to 16 under every trigger code in mode 0. This separates the four trigger thresholds from one another and from the simple non-empty rule. In mode 1, the receive and transmit counts are ramped up to full and back down to empty. Because the ramp down passes back through the trigger level, a sticky pin is told apart from one that merely tracks a threshold. A timeout with data held below the trigger level exercises the second way the receive pin can assert. Control writes that toggle the enable, repeat it, or set only one clear bit separate enable-change clearing from the explicit clear bits. Finally, a FIFO-disabled pass with the mode bit and the largest trigger code stored shows that both settings are overridden by the single holding register.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;

   typedef enum logic [1:0] {
      TRIG_1  = 2'b00,
      TRIG_4  = 2'b01,
      TRIG_8  = 2'b10,
      TRIG_14 = 2'b11
   } trig_sel_e;

   typedef struct packed {
      logic      en;
      logic      mode1;
      trig_sel_e trig;
   } fctl_t;

   // Occupancy that a trigger code stands for.
   function automatic int unsigned trig_level(input int unsigned code);
      case (code)
         0:       return 1;
         1:       return 4;
         2:       return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uart_fcr_decode.sv
module uart_fcr_decode
   import uart_fifo_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   output fctl_t      ctl,
   output logic       rx_clr,
   output logic       tx_clr
);

   logic en_flip;
   assign en_flip = wdata[0] ^ ctl.en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         rx_clr <= 1'b0;
         tx_clr <= 1'b0;
      end else begin
         // Clear requests are pulses only; an enable change empties both sides.
         rx_clr <= wr & (wdata[1] | en_flip);
         tx_clr <= wr & (wdata[2] | en_flip);
         if (wr) begin
            ctl.en    <= wdata[0];
            ctl.mode1 <= wdata[3];
            ctl.trig  <= trig_sel_e'(wdata[7:6]);
         end
      end
   end

endmodule

// File: rtl/uart_rx_ready.sv
module uart_rx_ready
   import uart_fifo_ctl_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fctl_t            ctl,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_timeout,
   output logic             trig_hit,
   output logic             rxrdy_n
);

   localparam int N_TRIG = 4;

   logic [N_TRIG-1:0] reach;
   logic              nonempty;
   logic              sticky;
   logic              act_q;
   logic              act_d;

   // One comparator per trigger code; the stored code picks one.
   for (genvar g = 0; g < N_TRIG; g++) begin : g_cmp
      assign reach[g] = rx_count >= CNT_W'(trig_level(g));
   end

   assign trig_hit = ctl.en ? reach[ctl.trig] : reach[0];
   assign nonempty = rx_count != '0;
   assign sticky   = ctl.en & ctl.mode1;

   always_comb begin
      if (sticky) act_d = nonempty & (act_q | trig_hit | rx_timeout);
      else        act_d = nonempty;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act_d;
   end

   assign rxrdy_n = ~act_q;

endmodule

// File: rtl/uart_tx_ready.sv
module uart_tx_ready
   import uart_fifo_ctl_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fctl_t            ctl,
   input  logic [CNT_W-1:0] tx_count,
   output logic             txrdy_n
);

   localparam logic [CNT_W-1:0] FULL_FIFO = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] FULL_HOLD = CNT_W'(1);

   logic [CNT_W-1:0] full_lvl;
   logic             empty;
   logic             full;
   logic             sticky;
   logic             act_q;
   logic             act_d;

   assign full_lvl = ctl.en ? FULL_FIFO : FULL_HOLD;
   assign empty    = tx_count == '0;
   assign full     = tx_count >= full_lvl;
   assign sticky   = ctl.en & ctl.mode1;

   always_comb begin
      if (sticky) act_d = empty | (act_q & ~full);
      else        act_d = empty;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= 1'b1;
      else        act_q <= act_d;
   end

   assign txrdy_n = ~act_q;

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
   import uart_fifo_ctl_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fcr_wr,
   input  logic [7:0]       fcr_wdata,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             rx_timeout,
   output logic             rx_clear,
   output logic             tx_clear,
   output logic             fifo_en,
   output logic             dma_mode1,
   output logic             rx_trig_reached,
   output logic             rxrdy_n,
   output logic             txrdy_n
);

   if (DEPTH < 14 || DEPTH > 255) begin : g_bad_depth
      $error("uart_fifo_ctl: DEPTH must hold the top trigger level and stay below 256");
   end

   fctl_t ctl;

   uart_fcr_decode i_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (fcr_wr),
      .wdata  (fcr_wdata),
      .ctl    (ctl),
      .rx_clr (rx_clear),
      .tx_clr (tx_clear)
   );

   uart_rx_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .rx_count   (rx_count),
      .rx_timeout (rx_timeout),
      .trig_hit   (rx_trig_reached),
      .rxrdy_n    (rxrdy_n)
   );

   uart_tx_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .tx_count (tx_count),
      .txrdy_n  (txrdy_n)
   );

   assign fifo_en   = ctl.en;
   assign dma_mode1 = ctl.mode1;

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fcr_wr,
   input logic [7:0]       fcr_wdata,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             rx_timeout,
   input logic             rx_clear,
   input logic             tx_clear,
   input logic             fifo_en,
   input logic             dma_mode1,
   input logic             rx_trig_reached,
   input logic             rxrdy_n,
   input logic             txrdy_n
);

   a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_wr |=> (fifo_en == $past(fcr_wdata[0])) && (dma_mode1 == $past(fcr_wdata[3])));

   a_r3_rx_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_wr && fcr_wdata[1] |=> rx_clear);

   a_r3_rx_clr_src: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clear |-> $past(fcr_wr));

   a_r4_tx_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_wr && fcr_wdata[2] |=> tx_clear);

   a_r4_tx_clr_src: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clear |-> $past(fcr_wr));

   a_r5_en_change: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_wr && (fcr_wdata[0] != fifo_en) |=> rx_clear && tx_clear);

   a_r6_lowest_trig: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fcr_wr && fcr_wdata[7:6] == 2'b00) && (rx_count != '0) |-> rx_trig_reached);

   a_r7_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_count) == '0 |-> rxrdy_n);

   a_r7_rx_plain: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(fifo_en && dma_mode1) && rx_count != '0) |-> !rxrdy_n);

   a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fifo_en && dma_mode1 && rx_timeout && rx_count != '0) |-> !rxrdy_n);

   a_r9_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_count) == '0 |-> !txrdy_n);

   a_r10_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_count) == CNT_W'(DEPTH) |-> txrdy_n);

   a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fifo_en && dma_mode1 && tx_count != '0 && tx_count != CNT_W'(DEPTH))
      |-> txrdy_n == $past(txrdy_n));

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fcr_wr          (fcr_wr),
   .fcr_wdata       (fcr_wdata),
   .rx_count        (rx_count),
   .tx_count        (tx_count),
   .rx_timeout      (rx_timeout),
   .rx_clear        (rx_clear),
   .tx_clear        (tx_clear),
   .fifo_en         (fifo_en),
   .dma_mode1       (dma_mode1),
   .rx_trig_reached (rx_trig_reached),
   .rxrdy_n         (rxrdy_n),
   .txrdy_n         (txrdy_n)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

   localparam int DEPTH = 16;
   localparam int CW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fcr_wr = 1'b0;
   logic [7:0]    fcr_wdata = 8'h00;
   logic [CW-1:0] rx_count = '0;
   logic [CW-1:0] tx_count = '0;
   logic          rx_timeout = 1'b0;
   logic          rx_clear, tx_clear, fifo_en, dma_mode1;
   logic          rx_trig_reached, rxrdy_n, txrdy_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   uart_fifo_ctl #(.DEPTH(DEPTH)) i_uart_fifo_ctl (
      .clk (clk), .rst_n (rst_n), .fcr_wr (fcr_wr), .fcr_wdata (fcr_wdata),
      .rx_count (rx_count), .tx_count (tx_count), .rx_timeout (rx_timeout),
      .rx_clear (rx_clear), .tx_clear (tx_clear), .fifo_en (fifo_en),
      .dma_mode1 (dma_mode1), .rx_trig_reached (rx_trig_reached),
      .rxrdy_n (rxrdy_n), .txrdy_n (txrdy_n)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int level(input bit en, input int code);
      if (!en) return 1;
      case (code)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   // Write the control byte, check the pulses in the next cycle and their end.
   task automatic wr_fcr(input logic [7:0] v, input int exp_rx, input int exp_tx);
      fcr_wr = 1'b1;
      fcr_wdata = v;
      step();
      fcr_wr = 1'b0;
      check("R3 rx_clear pulse", rx_clear, exp_rx);
      check("R4 tx_clear pulse", tx_clear, exp_tx);
      check("R2 fifo_en stored", fifo_en, int'(v[0]));
      check("R2 dma_mode1 stored", dma_mode1, int'(v[3]));
      step();
      check("R3 rx_clear one cycle", rx_clear, 0);
      check("R4 tx_clear one cycle", tx_clear, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit act;
      repeat (3) step();
      check("R1 rxrdy_n in reset", rxrdy_n, 1);
      check("R1 txrdy_n in reset", txrdy_n, 0);
      rst_n = 1'b1;
      step();
      check("R1 rxrdy_n after reset", rxrdy_n, 1);
      check("R1 txrdy_n after reset", txrdy_n, 0);
      check("R1 rx_clear", rx_clear, 0);
      check("R1 tx_clear", tx_clear, 0);
      check("R1 fifo_en", fifo_en, 0);
      check("R1 dma_mode1", dma_mode1, 0);

      // R5: enable change clears both; repeating it clears nothing.
      wr_fcr(8'h01, 1, 1);
      wr_fcr(8'h01, 0, 0);
      // R3 / R4: individual clear bits.
      wr_fcr(8'h03, 1, 0);
      wr_fcr(8'h05, 0, 1);

      // R6 / R7: mode 0 receive sweep under every trigger code.
      for (int t = 0; t < 4; t++) begin
         wr_fcr(8'(t << 6) | 8'h01, 0, 0);
         for (int c = 0; c <= DEPTH; c++) begin
            rx_count = CW'(c);
            step();
            check("R6 trigger level", rx_trig_reached, int'(c >= level(1, t)));
            check("R7 rxrdy_n mode0", rxrdy_n, int'(c == 0));
         end
      end

      // R8: mode 1 receive, ramp up and down under every trigger code.
      rx_count = '0;
      step();
      for (int t = 0; t < 4; t++) begin
         wr_fcr(8'(t << 6) | 8'h09, 0, 0);
         act = 0;
         for (int k = 0; k <= 2 * DEPTH; k++) begin
            int c;
            c = (k <= DEPTH) ? k : 2 * DEPTH - k;
            rx_count = CW'(c);
            step();
            act = (c != 0) && (act || c >= level(1, t));
            check("R8 rxrdy_n mode1 sticky", rxrdy_n, int'(!act));
         end
      end
      // R8: timeout below the trigger level.
      rx_count = 5'd2;
      step();
      check("R8 below trigger no request", rxrdy_n, 1);
      rx_timeout = 1'b1;
      step();
      check("R8 timeout asserts", rxrdy_n, 0);
      rx_timeout = 1'b0;
      rx_count = 5'd1;
      step();
      check("R8 holds after timeout", rxrdy_n, 0);
      rx_count = 5'd0;
      step();
      check("R8 empty releases", rxrdy_n, 1);

      // R9: mode 0 transmit sweep.
      wr_fcr(8'h01, 0, 0);
      for (int c = 0; c <= DEPTH; c++) begin
         tx_count = CW'(c);
         step();
         check("R9 txrdy_n mode0", txrdy_n, int'(c != 0));
      end

      // R10: mode 1 transmit ramp up to full and back to empty.
      wr_fcr(8'h09, 0, 0);
      tx_count = '0;
      step();
      act = 1;
      for (int k = 0; k <= 2 * DEPTH; k++) begin
         int c;
         c = (k <= DEPTH) ? k : 2 * DEPTH - k;
         tx_count = CW'(c);
         step();
         act = (c == 0) || (act && c < DEPTH);
         check("R10 txrdy_n mode1 sticky", txrdy_n, int'(!act));
      end

      // R11: FIFOs disabled with mode bit and top trigger code stored.
      tx_count = '0;
      rx_count = '0;
      wr_fcr(8'hC8, 1, 1);
      for (int c = 0; c <= 3; c++) begin
         tx_count = CW'(c);
         rx_count = CW'(c);
         step();
         check("R11 txrdy_n holding register", txrdy_n, int'(c != 0));
         check("R11 rxrdy_n holding register", rxrdy_n, int'(c == 0));
         check("R6 disabled trigger level", rx_trig_reached, int'(c >= 1));
      end
      tx_count = '0;
      step();
      check("R11 txrdy_n empty again", txrdy_n, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule